// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block takes a DDR SDRAM device from power-up to the point where normal traffic may begin. Once a system timer reports that power and clock have settled, the sequencer drives a fixed series of commands on the memory command pins. It first precharges every bank. It then loads the extended mode register to turn the DLL on, and loads the main mode register with the DLL-reset bit set. A second precharge-all follows, then two auto-refreshes, and a final mode-register load that holds the operating configuration. After the last wait it raises a done flag and holds the bus quiet until the next reset.

Every minimum spacing after a command (row precharge, refresh cycle, mode-register set) is given as a delay in picoseconds together with the clock period. The number of clocks is fixed when the design is built. Where one clock period already covers a delay, the wait state is removed and the next command follows on the next clock. The command, bank and address pins are registered, so each pin value reflects the state that the sequencer held one clock earlier. The state-code output shows the live state, which runs one clock ahead of the pins.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is active, and until the stabilization input has been sampled high, the pins show deselect (select, row, column and write strobes all 1), bank and address are 0, the done flag is 0 and the state code is 0.
- R2: On the clock after the stabilization input is first sampled high, the pins show a NOP. On the clock after that, they show the first precharge-all.
- R3: The commands appear in this order: precharge-all, extended load, DLL-reset load, precharge-all, auto-refresh, auto-refresh, configuration load.
- R4: The command encodings, written as {select, row, column, write} strobes, are: NOP 0111, precharge 0010, auto-refresh 0001, mode load 0000.
- R5: Each command is followed by a gap of ceil(delay/period) clocks before the next command (at least 1). The delay is tRP after a precharge, tRFC after a refresh and tMRD after a load. Only NOPs with address 0 and bank 0 appear in the gap. When the period covers the delay, the next command follows on the next clock.
- R6: A precharge-all drives address bit 10 high, with bank 0 and all other address bits 0.
- R7: The main mode loads use bank 00 and the word {op mode[12:7], CAS latency[6:4], burst type[3], burst length[2:0]}. Bit 8 is 1 in the DLL-reset load and 0 in the configuration load.
- R8: The extended load uses bank 01 and carries the configured extended word with bit 0 (DLL enable, active low) cleared.
- R9: After the configuration load and its wait, the done flag goes to 1 and the state code reads 16. From then on the pins show NOP until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stable_i | input | 1 | Power and clock stabilization delay has elapsed |
| state_o | output | 5 | Current sequencer state code (one clock ahead of the pins) |
| mem_sel_n | output | 1 | Chip-select strobe, active low |
| mem_row_n | output | 1 | Row strobe, active low |
| mem_col_n | output | 1 | Column strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_bank | output | BA_W | Bank address |
| mem_addr | output | ADDR_W | Address bus (mode words, precharge-all flag) |
| init_done | output | 1 | Initialization complete |

## Verification
The bound checker checks these properties on every cycle: only the four legal strobe patterns appear, a precharge always carries the all-banks bit, mode loads use only banks 00 and 01, an extended load keeps the DLL enabled, gap NOPs carry a zero address, the done flag never falls and the bus stays at NOP once done is high. It also counts clocks between commands and checks that no command arrives earlier than its predecessor's delay allows. Several things only the bench scenarios can show: that the exact order and the exact gap lengths match, that the mode words carry the configured fields with the DLL-reset bit set and then cleared, that the sequencer holds while the stabilization input is low, and that a reset in the middle of the sequence restarts it cleanly.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [4:0] {
    ST_IDLE       = 5'd0,
    ST_NOP        = 5'd1,
    ST_PRE_A      = 5'd2,
    ST_WAIT_RP_A  = 5'd3,
    ST_EXT_LOAD   = 5'd4,
    ST_WAIT_MRD_A = 5'd5,
    ST_DLL_LOAD   = 5'd6,
    ST_WAIT_MRD_B = 5'd7,
    ST_PRE_B      = 5'd8,
    ST_WAIT_RP_B  = 5'd9,
    ST_REF_A      = 5'd10,
    ST_WAIT_RFC_A = 5'd11,
    ST_REF_B      = 5'd12,
    ST_WAIT_RFC_B = 5'd13,
    ST_CFG_LOAD   = 5'd14,
    ST_WAIT_MRD_C = 5'd15,
    ST_READY      = 5'd16
  } seq_state_e;

  typedef struct packed {
    logic sel_n;
    logic row_n;
    logic col_n;
    logic wr_n;
  } cmd_pins_t;

  localparam cmd_pins_t CMD_DESEL = 4'b1111;
  localparam cmd_pins_t CMD_NOP   = 4'b0111;
  localparam cmd_pins_t CMD_PRE   = 4'b0010;
  localparam cmd_pins_t CMD_REF   = 4'b0001;
  localparam cmd_pins_t CMD_LOAD  = 4'b0000;

  // Command-to-command spacing in clocks: ceil(delay / period), never below 1.
  function automatic int clocks_for(input int delay_ps, input int tck_ps);
    int c;
    c = (delay_ps + tck_ps - 1) / tck_ps;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/ddr_init_fsm.sv
module ddr_init_fsm
  import ddr_init_pkg::*;
#(
  parameter int TCK_PS  = 5000,
  parameter int TRP_PS  = 15000,
  parameter int TRFC_PS = 72000,
  parameter int TMRD_PS = 10000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stable_i,
  output seq_state_e state
);
  // Wait-state clocks after each command kind (0 means the wait is bypassed).
  localparam int RP_W   = clocks_for(TRP_PS,  TCK_PS) - 1;
  localparam int RFC_W  = clocks_for(TRFC_PS, TCK_PS) - 1;
  localparam int MRD_W  = clocks_for(TMRD_PS, TCK_PS) - 1;
  localparam int MAX_W  = (RP_W > RFC_W) ? ((RP_W > MRD_W) ? RP_W : MRD_W)
                                         : ((RFC_W > MRD_W) ? RFC_W : MRD_W);
  localparam int CNT_W  = (MAX_W < 2) ? 1 : $clog2(MAX_W);

  seq_state_e       st, nxt;
  logic             ld, expired;
  logic [CNT_W-1:0] ld_val;

  ddr_init_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val), .expired(expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  always_comb begin
    nxt    = st;
    ld     = 1'b0;
    ld_val = '0;
    unique case (st)
      ST_IDLE:  if (stable_i) nxt = ST_NOP;
      ST_NOP:   nxt = ST_PRE_A;
      ST_PRE_A: begin
        if (RP_W == 0) nxt = ST_EXT_LOAD;
        else begin nxt = ST_WAIT_RP_A; ld = 1'b1; ld_val = CNT_W'(RP_W - 1); end
      end
      ST_WAIT_RP_A: if (expired) nxt = ST_EXT_LOAD;
      ST_EXT_LOAD: begin
        if (MRD_W == 0) nxt = ST_DLL_LOAD;
        else begin nxt = ST_WAIT_MRD_A; ld = 1'b1; ld_val = CNT_W'(MRD_W - 1); end
      end
      ST_WAIT_MRD_A: if (expired) nxt = ST_DLL_LOAD;
      ST_DLL_LOAD: begin
        if (MRD_W == 0) nxt = ST_PRE_B;
        else begin nxt = ST_WAIT_MRD_B; ld = 1'b1; ld_val = CNT_W'(MRD_W - 1); end
      end
      ST_WAIT_MRD_B: if (expired) nxt = ST_PRE_B;
      ST_PRE_B: begin
        if (RP_W == 0) nxt = ST_REF_A;
        else begin nxt = ST_WAIT_RP_B; ld = 1'b1; ld_val = CNT_W'(RP_W - 1); end
      end
      ST_WAIT_RP_B: if (expired) nxt = ST_REF_A;
      ST_REF_A: begin
        if (RFC_W == 0) nxt = ST_REF_B;
        else begin nxt = ST_WAIT_RFC_A; ld = 1'b1; ld_val = CNT_W'(RFC_W - 1); end
      end
      ST_WAIT_RFC_A: if (expired) nxt = ST_REF_B;
      ST_REF_B: begin
        if (RFC_W == 0) nxt = ST_CFG_LOAD;
        else begin nxt = ST_WAIT_RFC_B; ld = 1'b1; ld_val = CNT_W'(RFC_W - 1); end
      end
      ST_WAIT_RFC_B: if (expired) nxt = ST_CFG_LOAD;
      ST_CFG_LOAD: begin
        if (MRD_W == 0) nxt = ST_READY;
        else begin nxt = ST_WAIT_MRD_C; ld = 1'b1; ld_val = CNT_W'(MRD_W - 1); end
      end
      ST_WAIT_MRD_C: if (expired) nxt = ST_READY;
      ST_READY: nxt = ST_READY;
      default:  nxt = ST_IDLE;
    endcase
  end

  assign state = st;
endmodule

// File: rtl/ddr_init_pins.sv
module ddr_init_pins
  import ddr_init_pkg::*;
#(
  parameter int          ADDR_W   = 13,
  parameter int          BA_W     = 2,
  parameter logic [2:0]  BL_CODE  = 3'd2,
  parameter logic        BURST_IL = 1'b0,
  parameter logic [2:0]  CL_CODE  = 3'd2,
  parameter logic [5:0]  OP_MODE  = 6'd0,
  parameter logic [ADDR_W-1:0] EXT_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state,
  output cmd_pins_t         cmd,
  output logic [BA_W-1:0]   bank,
  output logic [ADDR_W-1:0] addr,
  output logic              done
);
  localparam int PRE_ALL_BIT = 10;
  localparam int DLL_RST_BIT = 8;
  localparam int DLL_OFF_BIT = 0;

  localparam logic [ADDR_W-1:0] MODE_BASE = ADDR_W'({OP_MODE, CL_CODE, BURST_IL, BL_CODE});
  localparam logic [ADDR_W-1:0] ONE       = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] WORD_DLL  = MODE_BASE |  (ONE << DLL_RST_BIT);
  localparam logic [ADDR_W-1:0] WORD_CFG  = MODE_BASE & ~(ONE << DLL_RST_BIT);
  localparam logic [ADDR_W-1:0] WORD_EXT  = EXT_WORD  & ~(ONE << DLL_OFF_BIT);
  localparam logic [ADDR_W-1:0] WORD_PRE  = ONE << PRE_ALL_BIT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd  <= CMD_DESEL;
      bank <= '0;
      addr <= '0;
      done <= 1'b0;
    end else begin
      cmd  <= CMD_NOP;
      bank <= '0;
      addr <= '0;
      done <= (state == ST_READY);
      unique case (state)
        ST_IDLE:               cmd <= CMD_DESEL;
        ST_PRE_A, ST_PRE_B:    begin cmd <= CMD_PRE;  addr <= WORD_PRE; end
        ST_EXT_LOAD:           begin cmd <= CMD_LOAD; addr <= WORD_EXT; bank <= BA_W'(1); end
        ST_DLL_LOAD:           begin cmd <= CMD_LOAD; addr <= WORD_DLL; end
        ST_CFG_LOAD:           begin cmd <= CMD_LOAD; addr <= WORD_CFG; end
        ST_REF_A, ST_REF_B:    cmd <= CMD_REF;
        default:               cmd <= CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int          TCK_PS   = 5000,
  parameter int          TRP_PS   = 15000,
  parameter int          TRFC_PS  = 72000,
  parameter int          TMRD_PS  = 10000,
  parameter int          ADDR_W   = 13,
  parameter int          BA_W     = 2,
  parameter logic [2:0]  BL_CODE  = 3'd2,
  parameter logic        BURST_IL = 1'b0,
  parameter logic [2:0]  CL_CODE  = 3'd2,
  parameter logic [5:0]  OP_MODE  = 6'd0,
  parameter logic [ADDR_W-1:0] EXT_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stable_i,
  output logic [4:0]        state_o,
  output logic              mem_sel_n,
  output logic              mem_row_n,
  output logic              mem_col_n,
  output logic              mem_wr_n,
  output logic [BA_W-1:0]   mem_bank,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              init_done
);
  seq_state_e st;
  cmd_pins_t  cmd;

  ddr_init_fsm #(
    .TCK_PS(TCK_PS), .TRP_PS(TRP_PS), .TRFC_PS(TRFC_PS), .TMRD_PS(TMRD_PS)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .stable_i(stable_i), .state(st)
  );

  ddr_init_pins #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .BL_CODE(BL_CODE), .BURST_IL(BURST_IL),
    .CL_CODE(CL_CODE), .OP_MODE(OP_MODE), .EXT_WORD(EXT_WORD)
  ) u_pins (
    .clk(clk), .rst_n(rst_n), .state(st),
    .cmd(cmd), .bank(mem_bank), .addr(mem_addr), .done(init_done)
  );

  assign state_o   = st;
  assign mem_sel_n = cmd.sel_n;
  assign mem_row_n = cmd.row_n;
  assign mem_col_n = cmd.col_n;
  assign mem_wr_n  = cmd.wr_n;
endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk
  import ddr_init_pkg::*;
#(
  parameter int TCK_PS  = 5000,
  parameter int TRP_PS  = 15000,
  parameter int TRFC_PS = 72000,
  parameter int TMRD_PS = 10000,
  parameter int ADDR_W  = 13,
  parameter int BA_W    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4:0]        state_o,
  input logic              mem_sel_n,
  input logic              mem_row_n,
  input logic              mem_col_n,
  input logic              mem_wr_n,
  input logic [BA_W-1:0]   mem_bank,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              init_done
);
  localparam int SP_RP  = clocks_for(TRP_PS,  TCK_PS);
  localparam int SP_RFC = clocks_for(TRFC_PS, TCK_PS);
  localparam int SP_MRD = clocks_for(TMRD_PS, TCK_PS);

  logic [3:0] c;
  logic       is_nop, is_pre, is_ref, is_load, issued;
  assign c       = {mem_sel_n, mem_row_n, mem_col_n, mem_wr_n};
  assign is_nop  = (c == 4'b0111);
  assign is_pre  = (c == 4'b0010);
  assign is_ref  = (c == 4'b0001);
  assign is_load = (c == 4'b0000);
  assign issued  = is_pre | is_ref | is_load;

  // Clocks since the last issued command and the kind of that command.
  logic [1:0]  last_kind;
  logic [15:0] gap;
  int          need;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_kind <= 2'd0;
      gap       <= '0;
    end else if (issued) begin
      last_kind <= is_pre ? 2'd1 : (is_ref ? 2'd2 : 2'd3);
      gap       <= 16'd1;
    end else if (gap != 16'hFFFF) begin
      gap <= gap + 16'd1;
    end
  end
  always_comb begin
    unique case (last_kind)
      2'd1:    need = SP_RP;
      2'd2:    need = SP_RFC;
      2'd3:    need = SP_MRD;
      default: need = 0;
    endcase
  end

  // R1
  idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_o) == 5'd0) |-> (mem_sel_n && !init_done));

  // R4
  legal_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_sel_n |-> (is_nop || is_pre || is_ref || is_load));

  // R5
  cmd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issued && last_kind != 2'd0) |-> (int'(gap) >= need));

  // R5
  nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_nop |-> (mem_addr == '0 && mem_bank == '0));

  // R6
  pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> mem_addr[10]);

  // R7
  load_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_load |-> (mem_bank == BA_W'(0) || mem_bank == BA_W'(1)));

  // R8
  ext_dll_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_load && mem_bank == BA_W'(1)) |-> !mem_addr[0]);

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R9
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (is_nop && state_o == 5'd16));
endmodule

bind ddr_init_seq ddr_init_seq_chk #(
  .TCK_PS(TCK_PS), .TRP_PS(TRP_PS), .TRFC_PS(TRFC_PS), .TMRD_PS(TMRD_PS),
  .ADDR_W(ADDR_W), .BA_W(BA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .state_o(state_o),
  .mem_sel_n(mem_sel_n), .mem_row_n(mem_row_n), .mem_col_n(mem_col_n),
  .mem_wr_n(mem_wr_n), .mem_bank(mem_bank), .mem_addr(mem_addr),
  .init_done(init_done)
);

// File: tb/sim_ddr_init_seq.sv
`timescale 1ns/1ps
module sim_ddr_init_seq;
  localparam int TCK_PS  = 4000;
  localparam int TRP_PS  = 12000;   // 3 clocks spacing
  localparam int TRFC_PS = 20000;   // 5 clocks spacing
  localparam int TMRD_PS = 4000;    // covered by one clock: wait bypassed
  localparam logic [2:0]  BL  = 3'd2;
  localparam logic        BT  = 1'b0;
  localparam logic [2:0]  CL  = 3'd2;
  localparam logic [5:0]  OPM = 6'd0;
  localparam logic [12:0] EXT = 13'h003;

  logic clk = 1'b0, rst_n = 1'b0, stable_i = 1'b0;
  logic [4:0] state_o;
  logic sel_n, row_n, col_n, wr_n, init_done;
  logic [1:0] bank;
  logic [12:0] addr;

  always #2 clk = ~clk;

  ddr_init_seq #(
    .TCK_PS(TCK_PS), .TRP_PS(TRP_PS), .TRFC_PS(TRFC_PS), .TMRD_PS(TMRD_PS),
    .ADDR_W(13), .BA_W(2), .BL_CODE(BL), .BURST_IL(BT), .CL_CODE(CL),
    .OP_MODE(OPM), .EXT_WORD(EXT)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .stable_i(stable_i), .state_o(state_o),
    .mem_sel_n(sel_n), .mem_row_n(row_n), .mem_col_n(col_n), .mem_wr_n(wr_n),
    .mem_bank(bank), .mem_addr(addr), .init_done(init_done)
  );

  typedef struct {
    logic [3:0]  cmd;
    logic [1:0]  ba;
    logic [12:0] a;
  } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0, cycles = 0;
  int eidx = -1;

  function automatic int spacing(input int d);
    int s;
    s = (d + TCK_PS - 1) / TCK_PS;
    return (s < 1) ? 1 : s;
  endfunction

  task automatic push(input logic [3:0] c, input logic [1:0] b, input logic [12:0] a);
    exp_t e;
    e.cmd = c; e.ba = b; e.a = a;
    q.push_back(e);
  endtask

  task automatic push_gap(input int d);
    for (int i = 0; i < spacing(d) - 1; i++) push(4'b0111, 2'd0, 13'd0);
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Build the expected pin stream from the requirements.
  initial begin
    logic [12:0] mode_word;
    mode_word = {OPM, CL, BT, BL};
    push(4'b0111, 2'd0, 13'd0);                  // R2 NOP
    push(4'b0010, 2'd0, 13'h400);                // R6 precharge-all
    push_gap(TRP_PS);
    push(4'b0000, 2'd1, EXT & ~13'h001);         // R8 extended load
    push_gap(TMRD_PS);
    push(4'b0000, 2'd0, mode_word | 13'h100);    // R7 DLL reset load
    push_gap(TMRD_PS);
    push(4'b0010, 2'd0, 13'h400);
    push_gap(TRP_PS);
    push(4'b0001, 2'd0, 13'd0);                  // R3 refresh
    push_gap(TRFC_PS);
    push(4'b0001, 2'd0, 13'd0);
    push_gap(TRFC_PS);
    push(4'b0000, 2'd0, mode_word & ~13'h100);   // R7 configuration load
    push_gap(TMRD_PS);
  end

  // Reference position: clocks since the edge that first saw stabilization.
  always @(posedge clk) begin
    if (!rst_n)            eidx <= -1;
    else if (eidx >= 0)    eidx <= eidx + 1;
    else if (stable_i)     eidx <= 0;
  end

  // Observed spacing tracking (R5).
  int last_issue = -1, last_need = 0;

  always @(negedge clk) begin
    exp_t  e;
    logic  exp_done;
    string tag;
    int    idx;
    logic [3:0] act;
    act = {sel_n, row_n, col_n, wr_n};
    exp_done = 1'b0;
    if (!rst_n || eidx <= 0) begin
      e.cmd = 4'b1111; e.ba = 2'd0; e.a = 13'd0; tag = "R1";
      if (!rst_n || eidx < 0)
        check(state_o == 5'd0, "R1", "idle state code", state_o, 0);
    end else begin
      idx = eidx - 1;
      if (idx < q.size()) begin
        e = q[idx];
        if (idx < 2)                 tag = "R2";
        else if (e.cmd == 4'b0111)   tag = "R5";
        else if (e.cmd == 4'b0010)   tag = "R6";
        else if (e.cmd == 4'b0001)   tag = "R3";
        else if (e.ba == 2'd1)       tag = "R8";
        else                         tag = "R7";
      end else begin
        e.cmd = 4'b0111; e.ba = 2'd0; e.a = 13'd0; exp_done = 1'b1; tag = "R9";
        check(state_o == 5'd16, "R9", "ready state code", state_o, 16);
      end
    end
    check(act == e.cmd, tag, "R4 command strobes", act, e.cmd);
    check(bank == e.ba, tag, "bank", bank, e.ba);
    check(addr == e.a,  tag, "address", addr, e.a);
    check(init_done == exp_done, tag, "done flag", init_done, exp_done);

    if (!rst_n) begin
      last_issue = -1;
    end else if (act == 4'b0010 || act == 4'b0001 || act == 4'b0000) begin
      if (last_issue >= 0)
        check(cycles - last_issue == last_need, "R5", "command gap",
              cycles - last_issue, last_need);
      last_issue = cycles;
      last_need  = (act == 4'b0010) ? spacing(TRP_PS) :
                   (act == 4'b0001) ? spacing(TRFC_PS) : spacing(TMRD_PS);
    end
  end

  always @(posedge clk) cycles <= cycles + 1;

  task automatic wait_clks(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Watchdog
  initial begin
    wait_clks(20000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset, then hold stabilization low for a while.
    wait_clks(5);
    rst_n = 1'b1;
    wait_clks(12);
    stable_i = 1'b1;
    // Run partway, then reset mid-sequence (R1 restart).
    wait_clks(9);
    rst_n = 1'b0; stable_i = 1'b0;
    wait_clks(3);
    rst_n = 1'b1;
    wait_clks(7);
    stable_i = 1'b1;
    // Full sequence to ready (R3, R5, R6, R7, R8, R9).
    while (!init_done) wait_clks(1);
    wait_clks(25);
    // Stabilization dropping after ready has no effect (R9).
    stable_i = 1'b0;
    wait_clks(10);
    finish_run();
  end
endmodule